// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits beside one processor on a snooping shared bus and gives that processor an atomic read-modify-write primitive split into two halves. A load-reserved request records a reservation: a valid flag and the block address it covers. It also issues a memory read for the word. A later store-conditional to the same block is allowed to write memory only if the reservation is still intact. The processor learns the outcome through a one-cycle status pulse.

The reservation is kept honest by watching the bus. Any store by another agent to the reserved cache block clears the flag. A store-conditional's own successful write appears on the bus as an ordinary store. That store cancels every other monitor that holds the same block, so several processors can reserve one address at once and only the first to commit succeeds. The snoop input is expected to carry only stores issued by other agents. All outputs are registered and appear one cycle after the request is sampled.

Top module: `lrsc_monitor`

## Requirements
- R1: A request with `req_op` = 2'b01 (load-reserved) sets the reservation flag and records the block address of `req_addr`. One cycle later `mem_rd_en` is 1 with `mem_rd_addr` equal to `req_addr`.
- R2: A request with `req_op` = 2'b10 (store-conditional) succeeds when the flag is set and its block matches the reserved block. One cycle later it produces `mem_wr_en` = 1 with the request's address and data, together with `sc_done` = 1 and `sc_ok` = 1.
- R3: A store-conditional that fails the check gives `sc_done` = 1, `sc_ok` = 0 and `mem_wr_en` = 0 one cycle later.
- R4: Every store-conditional, passing or failing, leaves the reservation flag cleared.
- R5: A snooped write (`snoop_wr` = 1) whose block matches the reserved block clears the flag. A snoop with `snoop_wr` = 0, or a snooped write to another block, leaves the flag unchanged.
- R6: Address comparison uses block granularity. The low `OFFS_W` bits (default 4) of every address are ignored.
- R7: A load-reserved replaces any existing reservation with the new block.
- R8: A snooped write to the reserved block in the same cycle as a store-conditional makes that store-conditional fail.
- R9: A load-reserved in the same cycle as a snooped write to its block still leaves the flag set for the new block.
- R10: Synchronous active-high reset clears the flag and every output.
- R11: `req_op` values 2'b00 and 2'b11 are idle. They cause no read, no write and no status pulse, and they leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2 | 00 idle, 01 load-reserved, 10 store-conditional, 11 idle |
| req_addr | input | AW | Request byte address |
| req_wdata | input | DW | Store-conditional data |
| snoop_wr | input | 1 | Another agent's bus store is visible this cycle |
| snoop_addr | input | AW | Address of the snooped bus store |
| mem_rd_en | output | 1 | Read issued for a load-reserved |
| mem_rd_addr | output | AW | Read address |
| mem_wr_en | output | 1 | Write issued by a successful store-conditional |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Write data |
| sc_done | output | 1 | Store-conditional outcome is valid |
| sc_ok | output | 1 | Store-conditional succeeded |
| rsv_valid | output | 1 | Current reservation flag |

## Verification
The bench targets three collision cases:
- **Snoop and store-conditional in the same cycle.** A monitor that checked only the registered flag would let the store-conditional through and write memory over another agent's store.
- **Snoop and load-reserved in the same cycle.** If the clear took priority over the set, the fresh reservation would be lost.
- **Addresses that differ only in the offset bits.** A word-granular compare would wrongly fail store-conditionals, and it would ignore snooped stores to a neighbouring word of the reserved block.

The bench also checks that a failed store-conditional clears the flag, so a retry without a new load-reserved must fail. Random traffic drawn from a small block pool then makes hits, misses and overwrites frequent.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_LR   = 2'b01,
    OP_SC   = 2'b10,
    OP_RSVD = 2'b11
  } lrsc_op_e;
endpackage

// File: rtl/lrsc_blk_match.sv
module lrsc_blk_match #(
  parameter int AW     = 32,
  parameter int OFFS_W = 4,
  localparam int TW    = AW - OFFS_W
) (
  input  logic [AW-1:0] addr,
  input  logic [TW-1:0] tag,
  output logic          hit
);
  always_comb hit = (addr[AW-1:OFFS_W] == tag);
endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
  parameter int TW = 28
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set,
  input  logic          clr,
  input  logic [TW-1:0] set_tag,
  output logic          vld,
  output logic [TW-1:0] tag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      tag <= '0;
    end else if (set) begin
      vld <= 1'b1;
      tag <= set_tag;
    end else if (clr) begin
      vld <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set |=> vld); // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !vld); // R4
endmodule

// File: rtl/lrsc_out_stage.sv
module lrsc_out_stage #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_go,
  input  logic          wr_go,
  input  logic          sc_go,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          sc_done,
  output logic          sc_ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      sc_done     <= 1'b0;
      sc_ok       <= 1'b0;
    end else begin
      mem_rd_en <= rd_go;
      mem_wr_en <= wr_go;
      sc_done   <= sc_go;
      sc_ok     <= wr_go;
      if (rd_go) mem_rd_addr <= addr;
      if (wr_go) begin
        mem_wr_addr <= addr;
        mem_wr_data <= data;
      end
    end
  end

  AST_OK_IMPLIES_DONE: assert property (@(posedge clk) disable iff (rst)
    sc_ok |-> sc_done); // R2
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd_en, mem_wr_en})); // R1
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int OFFS_W = 4,
  localparam int TW    = AW - OFFS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          snoop_wr,
  input  logic [AW-1:0] snoop_addr,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          sc_done,
  output logic          sc_ok,
  output logic          rsv_valid
);
  lrsc_op_e      op;
  logic          lr_req, sc_req;
  logic          rsv_vld;
  logic [TW-1:0] rsv_tag;
  logic          req_hit, snp_hit;
  logic          snoop_kill, sc_pass;

  always_comb begin
    op         = lrsc_op_e'(req_op);
    lr_req     = (op == OP_LR);
    sc_req     = (op == OP_SC);
    snoop_kill = snoop_wr && snp_hit && rsv_vld;
    sc_pass    = sc_req && rsv_vld && req_hit && !snoop_kill;
  end

  lrsc_blk_match #(.AW(AW), .OFFS_W(OFFS_W)) u_req_match (
    .addr(req_addr), .tag(rsv_tag), .hit(req_hit));

  lrsc_blk_match #(.AW(AW), .OFFS_W(OFFS_W)) u_snp_match (
    .addr(snoop_addr), .tag(rsv_tag), .hit(snp_hit));

  lrsc_resv_reg #(.TW(TW)) u_resv (
    .clk(clk), .rst(rst),
    .set(lr_req), .clr(sc_req || snoop_kill),
    .set_tag(req_addr[AW-1:OFFS_W]),
    .vld(rsv_vld), .tag(rsv_tag));

  lrsc_out_stage #(.AW(AW), .DW(DW)) u_out (
    .clk(clk), .rst(rst),
    .rd_go(lr_req), .wr_go(sc_pass), .sc_go(sc_req),
    .addr(req_addr), .data(req_wdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data),
    .sc_done(sc_done), .sc_ok(sc_ok));

  always_comb rsv_valid = rsv_vld;

  AST_LR_SETS: assert property (@(posedge clk) disable iff (rst)
    (req_op == 2'b01) |=> rsv_valid); // R1
  AST_SC_NEEDS_RESV: assert property (@(posedge clk) disable iff (rst)
    (req_op == 2'b10 && !rsv_valid) |=> (sc_done && !sc_ok)); // R3
  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (req_op == 2'b10) |=> !rsv_valid); // R4
  AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (snoop_wr && rsv_valid && snoop_addr[AW-1:OFFS_W] == rsv_tag && req_op != 2'b01)
      |=> !rsv_valid); // R5
  AST_SNOOP_BEATS_SC: assert property (@(posedge clk) disable iff (rst)
    (req_op == 2'b10 && snoop_wr && snoop_addr[AW-1:OFFS_W] == req_addr[AW-1:OFFS_W])
      |=> !mem_wr_en); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (req_op == 2'b00 || req_op == 2'b11) |=> !(mem_rd_en || mem_wr_en || sc_done)); // R11
  AST_WR_MEANS_OK: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> sc_ok); // R2
endmodule

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb;
  localparam int AW = 32, DW = 32, OFFS_W = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          snoop_wr = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          mem_rd_en, mem_wr_en, sc_done, sc_ok, rsv_valid;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  int checks = 0;
  int errors = 0;
  bit m_vld = 1'b0;
  logic [AW-1:0] m_addr = '0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lrsc_monitor #(.AW(AW), .DW(DW), .OFFS_W(OFFS_W)) u_dut (
    .clk(clk), .rst(rst), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .snoop_wr(snoop_wr), .snoop_addr(snoop_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .sc_done(sc_done), .sc_ok(sc_ok),
    .rsv_valid(rsv_valid));

  function automatic bit same_blk(logic [AW-1:0] a, logic [AW-1:0] b);
    return a[AW-1:OFFS_W] == b[AW-1:OFFS_W];
  endfunction

  function automatic bit sc_expect(bit v, logic [AW-1:0] ra, logic [AW-1:0] a,
                                   bit sw, logic [AW-1:0] sa);
    return v && same_blk(ra, a) && !(sw && same_blk(sa, ra));
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                      bit sw, logic [AW-1:0] sa, string tag);
    bit e_rd, e_wr, e_done, e_vld;
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; snoop_wr = sw; snoop_addr = sa;
    e_rd = (op == 2'b01);
    e_done = (op == 2'b10);
    e_wr = e_done && sc_expect(m_vld, m_addr, a, sw, sa);
    e_vld = m_vld;
    if (sw && m_vld && same_blk(sa, m_addr)) e_vld = 1'b0;
    if (op == 2'b10) e_vld = 1'b0;
    if (op == 2'b01) begin e_vld = 1'b1; m_addr = a; end
    m_vld = e_vld;
    @(posedge clk); #1;
    chk(mem_rd_en == e_rd, tag, "mem_rd_en", mem_rd_en, e_rd);
    chk(mem_wr_en == e_wr, tag, "mem_wr_en", mem_wr_en, e_wr);
    chk(sc_done == e_done, tag, "sc_done", sc_done, e_done);
    chk(sc_ok == e_wr, tag, "sc_ok", sc_ok, e_wr);
    chk(rsv_valid == e_vld, tag, "rsv_valid", rsv_valid, e_vld);
    if (e_rd) chk(mem_rd_addr == a, tag, "mem_rd_addr", mem_rd_addr, a);
    if (e_wr) begin
      chk(mem_wr_addr == a, tag, "mem_wr_addr", mem_wr_addr, a);
      chk(mem_wr_data == d, tag, "mem_wr_data", mem_wr_data, d);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [AW-1:0] A = 32'h0000_1000;
  localparam logic [AW-1:0] B = 32'h0000_2000;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R10 reset state
    chk(!rsv_valid && !mem_rd_en && !mem_wr_en && !sc_done && !sc_ok, "R10",
        "outputs after reset", {rsv_valid, mem_rd_en, mem_wr_en, sc_done, sc_ok}, 0);
    step(2'b01, A, 0, 0, 0, "R1");
    step(2'b10, A + 4, 32'hCAFE, 0, 0, "R2_R6");
    step(2'b10, A, 32'h1, 0, 0, "R3_R4");
    step(2'b10, A, 32'h2, 0, 0, "R3");
    step(2'b01, A, 0, 0, 0, "R1");
    step(2'b00, 0, 0, 1, A + 8, "R5_R6");
    step(2'b10, A, 32'h3, 0, 0, "R5");
    step(2'b01, A, 0, 0, 0, "R1");
    step(2'b00, 0, 0, 0, A, "R5_nowr");
    step(2'b00, 0, 0, 1, B, "R5_other");
    step(2'b11, B, 0, 0, 0, "R11");
    step(2'b10, A + 12, 32'h4, 1, A, "R8");
    step(2'b01, A, 0, 0, 0, "R7");
    step(2'b01, B, 0, 0, 0, "R7");
    step(2'b10, A, 32'h5, 0, 0, "R7_fail");
    step(2'b01, B, 0, 1, B + 4, "R9");
    step(2'b10, B, 32'h6, 0, 0, "R9_ok");
    step(2'b01, A, 0, 0, 0, "R1");
    step(2'b10, B, 32'h7, 0, 0, "R3_miss");
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] ra, sa;
      ra = {24'h0, 4'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
      sa = {24'h0, 4'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
      step(2'($urandom), ra, $urandom, 1'($urandom_range(0, 3) == 0), sa, "RAND");
    end
    @(negedge clk); rst = 1'b1; req_op = 2'b01;
    @(posedge clk); #1;
    chk(!rsv_valid && !mem_rd_en, "R10", "reset over request",
        {rsv_valid, mem_rd_en}, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule